// File: doc/BRIEF.md
# Multi-mode timer/counter with prescaler

This block is a 16-bit timer/counter made of a low byte and a high byte. A two-bit mode field either runs the bytes as separate 8-bit units or joins them into one 16-bit word. Timer halves advance on ticks from a cascaded prescaler. The first stage of that prescaler divides the cycle-enable strobe by a fixed four. The second stage is an 8-bit programmable divider. Counter halves advance on qualified rising edges of an external event input.

Each half compares its count with a match register. When a count arrives while the half is at its match value, the half returns to zero and sets its own flag. The flags drive two level interrupt requests. Software clears a flag by writing 1 to it. Control, prescaler value, match values, counts and flags are all reached through a simple write port and a combinational read port.

Mode encoding: 0 runs two independent prescaled 8-bit timers. 1 runs a prescaled timer in the low byte and an event counter in the high byte. 2 runs a 16-bit prescaled timer. 3 runs a 16-bit event counter.

Top module: `evt_tmr16`

## Requirements
- R1: After reset every register (control, prescaler value, both match values, both counts, both flags) reads 0, and both interrupt requests are low.
- R2: A prescaler tick occurs once every 4*(P+1) cycles in which cyc_en is high and run is set, where P is the prescaler value. A cycle with cyc_en low advances nothing.
- R3: A write to the prescaler register (address 1) restarts both prescaler stages from zero. No tick occurs in the cycle of that write.
- R4: In mode 0 (control bits [1:0] = 0), the low and the high byte each advance by one on every prescaler tick, each against its own match value.
- R5: In mode 1, the low byte advances on prescaler ticks and the high byte advances on accepted event edges.
- R6: In mode 2, the 16-bit word {high, low} advances by one on every prescaler tick. It compares against {match high, match low}.
- R7: In mode 3, the 16-bit word advances by one on every accepted event edge.
- R8: A count that arrives while a half (or the 16-bit word) equals its match value sets it to 0 and sets its flag. Otherwise the count increments, wrapping modulo its width without setting a flag.
- R9: Flags read at address 6, with bit 0 for the low flag and bit 1 for the high flag. Writing 1 to a bit clears it. A set in the same cycle wins over the clear. irq_hi equals the high flag.
- R10: In modes 2 and 3 the low flag is never set, and irq_lo is held low even if the low flag is already set. In modes 0 and 1, irq_lo equals the low flag.
- R11: An event edge is accepted only when the synchronised input is high and was low on each of the two cycles before. A low pulse of only one cycle between high levels is not counted.
- R12: With run (control bit 2) clear, the counts hold their values whatever cyc_en and evt_in do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable strobe that feeds the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 prescaler, 2 match low, 3 match high, 6 flags |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address: 0 to 3 as written, 4 count low, 5 count high, 6 flags |
| rd_data | output | 8 | Combinational read data |
| evt_in | input | 1 | External event input, asynchronous |
| irq_lo | output | 1 | Low-byte interrupt request |
| irq_hi | output | 1 | High-byte interrupt request |

## Verification
The timing of each result, counted from the clock edge that samples the stimulus, is as follows.
- A register write is visible on rd_data right after the edge that samples the write.
- A prescaler tick changes the count at the same edge that sees the qualifying cyc_en. The flag and the interrupt request change at that edge as well.
- An event level that is sampled at edge k reaches the counters at edge k+2, after the two synchroniser flops.

The bench keeps a behavioural model that is updated on every rising edge from the same inputs. On every falling edge it compares irq_lo, irq_hi and the read data. The read address rotates through the whole map, so every register is compared in turn, one cycle after the model has settled.

// File: rtl/evt_tmr16.sv
module evt_tmr16 #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [BW-1:0] rd_data,
  input  logic          evt_in,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam int WW = 2 * BW;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_PRE  = 3'd1;
  localparam logic [2:0] A_MLO  = 3'd2;
  localparam logic [2:0] A_MHI  = 3'd3;
  localparam logic [2:0] A_CLO  = 3'd4;
  localparam logic [2:0] A_CHI  = 3'd5;
  localparam logic [2:0] A_FLG  = 3'd6;

  logic [1:0]    mode;
  logic          run;
  logic [BW-1:0] pre_val, m_lo, m_hi, c_lo, c_hi, pcnt;
  logic [1:0]    fix;
  logic          flag_lo, flag_hi;
  logic [3:0]    sy;

  logic pre_wr, tick2, ptick, edge_ok, casc;
  logic inc_lo, inc_hi8, lo_hit, hi_hit, w_hit, set_lo, set_hi;
  logic [1:0] clr;
  logic [WW-1:0] word, w_next;

  assign pre_wr  = wr_en && (wr_addr == A_PRE);
  assign tick2   = run && cyc_en && (fix == 2'd3);
  assign ptick   = tick2 && (pcnt == pre_val) && !pre_wr;
  assign edge_ok = run && sy[1] && !sy[2] && !sy[3];
  assign casc    = mode[1];

  assign inc_lo  = (mode == 2'd3) ? edge_ok : ptick;
  assign inc_hi8 = (mode == 2'd1) ? edge_ok : ptick;
  assign lo_hit  = (c_lo == m_lo);
  assign hi_hit  = (c_hi == m_hi);
  assign word    = {c_hi, c_lo};
  assign w_hit   = (word == {m_hi, m_lo});
  assign w_next  = w_hit ? '0 : word + WW'(1);
  assign set_lo  = !casc && inc_lo && lo_hit;
  assign set_hi  = casc ? (inc_lo && w_hit) : (inc_hi8 && hi_hit);
  assign clr     = (wr_en && wr_addr == A_FLG) ? wr_data[1:0] : 2'b00;

  assign irq_lo  = flag_lo && !casc;
  assign irq_hi  = flag_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= '0;
      run     <= 1'b0;
      pre_val <= '0;
      m_lo    <= '0;
      m_hi    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          mode <= wr_data[1:0];
          run  <= wr_data[2];
        end
        A_PRE:   pre_val <= wr_data;
        A_MLO:   m_lo    <= wr_data;
        A_MHI:   m_hi    <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pre_wr) begin
      fix  <= '0;
      pcnt <= '0;
    end else if (run && cyc_en) begin
      fix <= fix + 2'd1;
      if (tick2) pcnt <= (pcnt == pre_val) ? '0 : pcnt + BW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[2:0], evt_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_lo <= '0;
      c_hi <= '0;
    end else if (casc) begin
      if (inc_lo) {c_hi, c_lo} <= w_next;
    end else begin
      if (inc_lo)  c_lo <= lo_hit ? '0 : c_lo + BW'(1);
      if (inc_hi8) c_hi <= hi_hit ? '0 : c_hi + BW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
    end else begin
      flag_lo <= set_lo || (flag_lo && !clr[0]);
      flag_hi <= set_hi || (flag_hi && !clr[1]);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = BW'({run, mode});
      A_PRE:   rd_data = pre_val;
      A_MLO:   rd_data = m_lo;
      A_MHI:   rd_data = m_hi;
      A_CLO:   rd_data = c_lo;
      A_CHI:   rd_data = c_hi;
      A_FLG:   rd_data = BW'({flag_hi, flag_lo});
      default: rd_data = '0;
    endcase
  end

  p_pre_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wr |=> (pcnt == '0 && fix == '0));

  p_lo_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc && ptick && c_lo == m_lo) |=> (c_lo == '0 && flag_lo));

  p_w1c_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_FLG && wr_data[1] && !set_hi) |=> !flag_hi);

  p_casc_no_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !flag_lo) |=> !flag_lo);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(c_lo) && $stable(c_hi)));

  p_tick_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptick |-> (cyc_en && run));
endmodule

// File: tb/sim_evt_tmr16.sv
module sim_evt_tmr16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic evt_in = 1'b0;
  logic irq_lo, irq_hi;

  evt_tmr16 #(.BW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .evt_in(evt_in), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit chk_on = 0;
  int cyc_pat = 0;
  int pat_cnt = 0;

  int m_mode, m_run, m_pre, m_mlo, m_mhi, m_clo, m_chi, m_pc, m_flo, m_fhi;
  int hq[$];

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp_v, $time);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_run * 4 + m_mode;
      1: return m_pre;
      2: return m_mlo;
      3: return m_mhi;
      4: return m_clo;
      5: return m_chi;
      6: return m_fhi * 2 + m_flo;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int tick, ev, slo, shi, src, w, mw, clr;
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_pre = 0; m_mlo = 0; m_mhi = 0;
      m_clo = 0; m_chi = 0; m_pc = 0; m_flo = 0; m_fhi = 0;
      hq = '{0, 0, 0, 0};
    end else begin
      tick = 0;
      if (wr_en && wr_addr == 3'd1) m_pc = 0;
      else if (m_run != 0 && cyc_en) begin
        if (m_pc == 4 * m_pre + 3) begin tick = 1; m_pc = 0; end
        else m_pc++;
      end
      ev = (m_run != 0 && hq[1] == 1 && hq[2] == 0 && hq[3] == 0) ? 1 : 0;
      slo = 0; shi = 0;
      if (m_mode >= 2) begin
        src = (m_mode == 3) ? ev : tick;
        if (src != 0) begin
          w = m_chi * 256 + m_clo;
          mw = m_mhi * 256 + m_mlo;
          if (w == mw) begin w = 0; shi = 1; end
          else w = (w + 1) % 65536;
          m_chi = w / 256;
          m_clo = w % 256;
        end
      end else begin
        if (tick != 0) begin
          if (m_clo == m_mlo) begin m_clo = 0; slo = 1; end
          else m_clo = (m_clo + 1) % 256;
        end
        src = (m_mode == 1) ? ev : tick;
        if (src != 0) begin
          if (m_chi == m_mhi) begin m_chi = 0; shi = 1; end
          else m_chi = (m_chi + 1) % 256;
        end
      end
      clr = (wr_en && wr_addr == 3'd6) ? int'(wr_data) : 0;
      m_flo = (slo != 0 || (m_flo != 0 && clr % 2 == 0)) ? 1 : 0;
      m_fhi = (shi != 0 || (m_fhi != 0 && (clr / 2) % 2 == 0)) ? 1 : 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = int'(wr_data) % 4; m_run = (int'(wr_data) / 4) % 2; end
          3'd1: m_pre = int'(wr_data);
          3'd2: m_mlo = int'(wr_data);
          3'd3: m_mhi = int'(wr_data);
          default: ;
        endcase
      end
      hq.push_front(int'(evt_in));
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk(tag, int'(irq_lo), (m_mode < 2) ? m_flo : 0, "irq_lo");
      chk(tag, int'(irq_hi), m_fhi, "irq_hi");
      chk(tag, int'(rd_data), exp_rd(int'(rd_addr)), $sformatf("rd addr %0d", rd_addr));
      rd_addr = (rd_addr == 3'd6) ? 3'd0 : rd_addr + 3'd1;
    end
  end

  always @(negedge clk) begin
    pat_cnt++;
    case (cyc_pat)
      0: cyc_en = 1'b1;
      1: cyc_en = (pat_cnt % 4 != 0);
      default: cyc_en = (pat_cnt % 2 == 0);
    endcase
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi_n, input int lo_n);
    repeat (hi_n) begin @(negedge clk); evt_in = 1'b1; end
    repeat (lo_n) begin @(negedge clk); evt_in = 1'b0; end
  endtask

  task automatic stim();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(irq_lo), 0, "irq_lo after reset");
    chk("R1", int'(irq_hi), 0, "irq_hi after reset");
    chk("R1", int'(rd_data), 0, "rd after reset");
    chk_on = 1;
    idle(8);
    tag = "R4";
    cyc_pat = 1;
    wr(2, 3); wr(3, 5); wr(1, 1); wr(0, 4);
    idle(300);
    tag = "R9";
    wr(6, 1); idle(20); wr(6, 2); idle(20); wr(6, 3); idle(40);
    tag = "R3";
    wr(1, 4); idle(13); wr(1, 4); idle(50); wr(1, 0); idle(30);
    tag = "R2";
    cyc_pat = 2; idle(100); cyc_pat = 0; idle(60); cyc_pat = 1;
    tag = "R5";
    wr(0, 5);
    pulse(3, 3); pulse(1, 2); pulse(5, 2); pulse(2, 4); pulse(1, 3);
    pulse(4, 2); pulse(2, 2); pulse(3, 5); idle(20);
    tag = "R11";
    repeat (6) pulse(3, 1);
    pulse(1, 2); pulse(2, 1); pulse(2, 3); idle(20);
    tag = "R10";
    wr(2, 8'h20); wr(3, 1); wr(0, 6);
    wr(6, 2);
    tag = "R6";
    idle(2500);
    tag = "R7";
    wr(2, 9); wr(3, 0); wr(0, 7);
    repeat (24) pulse(2, 3);
    idle(10);
    tag = "R12";
    wr(0, 3);
    repeat (10) pulse(2, 2);
    idle(100);
    tag = "R8";
    wr(2, 8'hFF); wr(3, 0); wr(6, 3); wr(0, 4);
    idle(2200);
    wr(6, 3); idle(20);
  endtask

  initial begin
    fork
      stim();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule